// File: doc/BRIEF.md
# I2C Slave Address Receiver

This block is the receive side of a 7-bit I2C slave. It watches SCL and SDA, which pass through a synchronizer first, and finds START and STOP conditions. It shifts in the byte that follows each START and decides whether that byte names this device. A byte of all zeros is a general call. A byte equal to the programmed own address with the direction bit at 0 is a direct hit. Either outcome sets its own flag and sends a one-cycle interrupt pulse to the host. Any other byte clears both flags and makes the block ignore the rest of the transfer.

After a hit, the host takes data bytes one at a time. Each byte is first armed by a `rearm` strobe, which stands for the host writing a dummy byte into the shift register. A completed byte that was armed is latched into `rxData`, and `rxValid` is raised. An optional mode drives the acknowledge by pulling SDA low during the ninth clock. With that mode off, the block never touches the bus. A STOP ends the session. A repeated START begins address comparison again.

Top module: `i2c_slave_rx`

## Requirements
- R1: A START is SDA falling while SCL is high, and it sets `inSession` to 1. A STOP is SDA rising while SCL is high, and it sets `inSession` to 0.
- R2: Bits are sampled on SCL rising edges, most significant bit first, eight bits per byte.
- R3: A first byte of 8'h00 sets `genCallFlag`=1 and `addrMatchFlag`=0 and raises one `irq` pulse.
- R4: A first byte equal to {`ownAddr`, 1'b0} sets `addrMatchFlag`=1 and `genCallFlag`=0 and raises one `irq` pulse.
- R5: Any other first byte, including {`ownAddr`,1'b1}, clears both flags and raises no `irq` and no acknowledge. Later bytes of that session are neither stored nor acknowledged, even when armed.
- R6: With `ackEnable`=1, `sdaPullLow` is 1 during the ninth SCL clock that follows a matched address or an armed data byte.
- R7: With `ackEnable`=0, `sdaPullLow` stays 0.
- R8: A data byte completed while armed is latched into `rxData`, sets `rxValid`, and raises no `irq`. A `rearm` pulse clears `rxValid` and arms the next byte.
- R9: A data byte completed while not armed leaves `rxData` and `rxValid` unchanged and is not acknowledged.
- R10: A repeated START before a STOP clears both flags and compares the next byte as an address.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line, asynchronous |
| sdaIn | input | 1 | Bus data line, asynchronous |
| ownAddr | input | 7 | Programmed slave address |
| ackEnable | input | 1 | 1 = drive acknowledge |
| rearm | input | 1 | Host strobe arming the next data byte |
| sdaPullLow | output | 1 | 1 = pull SDA low (open drain) |
| irq | output | 1 | One-cycle pulse on general call or address match |
| genCallFlag | output | 1 | General-call status |
| addrMatchFlag | output | 1 | Own-address status |
| inSession | output | 1 | Between START and STOP |
| rxData | output | 8 | Last received data byte |
| rxValid | output | 1 | `rxData` holds an unread byte |

## Verification
Every bus event reaches the outputs three clocks after the pin changes: two synchronizer stages, then one registered decision. This applies to the flags, `irq`, `rxData`, `rxValid` and the rise or fall of `inSession` and `sdaPullLow`. The bench holds each SCL phase for eight clocks. It reads the flags and data only after the ninth clock of a byte has fully ended, and it samples the acknowledge in the middle of the ninth SCL high phase. It counts `irq` pulses on the falling clock edge and compares the count instead of catching a single cycle.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_DATA, ST_DATA_ACK, ST_SKIP
  } rxState_t;

  typedef struct packed {
    logic clearFlags;
    logic cntClr;
    logic shiftEn;
    logic evalAddr;
    logic storeData;
    logic ackSet;
    logic ackClr;
  } rxStrobe_t;
endpackage

// File: rtl/i2c_rx_datapath.sv
module i2c_rx_datapath
  import i2c_rx_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              rearm,
  input  rxStrobe_t         strobe,
  output logic              startDet,
  output logic              stopDet,
  output logic              sclRise,
  output logic              sclFall,
  output logic              bitLast,
  output logic              addrHit,
  output logic              armed,
  output logic              irq,
  output logic              genCallFlag,
  output logic              addrMatchFlag,
  output logic              sdaPullLow,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic                   sclPrev, sdaPrev, sclNow, sdaNow;
  logic [BYTE_W-1:0]      shiftReg, nextByte;
  logic [CNT_W-1:0]       bitCnt;
  logic                   isGenCall, isOwn;

  // synchronizers reset high so an idle bus gives no false edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow   = sclPipe[SYNC_STAGES-1];
  assign sdaNow   = sdaPipe[SYNC_STAGES-1];
  assign startDet = sclNow && sclPrev && sdaPrev && !sdaNow;
  assign stopDet  = sclNow && sclPrev && !sdaPrev && sdaNow;
  assign sclRise  = sclNow && !sclPrev;
  assign sclFall  = !sclNow && sclPrev;

  assign nextByte  = {shiftReg[BYTE_W-2:0], sdaNow};
  assign isGenCall = (nextByte == '0);
  assign isOwn     = !isGenCall && (nextByte[BYTE_W-1:1] == ownAddr) && !nextByte[0];
  assign addrHit   = isGenCall || isOwn;
  assign bitLast   = (bitCnt == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strobe.cntClr) begin
      bitCnt <= '0;
    end else if (strobe.shiftEn) begin
      shiftReg <= nextByte;
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genCallFlag   <= 1'b0;
      addrMatchFlag <= 1'b0;
      irq           <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (strobe.clearFlags) begin
        genCallFlag   <= 1'b0;
        addrMatchFlag <= 1'b0;
      end else if (strobe.evalAddr) begin
        genCallFlag   <= isGenCall;
        addrMatchFlag <= isOwn;
        irq           <= addrHit;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxValid <= 1'b0;
      armed   <= 1'b0;
    end else if (strobe.storeData) begin
      rxData  <= nextByte;
      rxValid <= 1'b1;
      armed   <= 1'b0;
    end else if (strobe.clearFlags) begin
      armed <= 1'b0;
    end else if (rearm) begin
      rxValid <= 1'b0;
      armed   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sdaPullLow <= 1'b0;
    else if (strobe.ackClr) sdaPullLow <= 1'b0;
    else if (strobe.ackSet) sdaPullLow <= 1'b1;
  end
endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
  import i2c_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      bitLast,
  input  logic      addrHit,
  input  logic      armed,
  input  logic      ackEnable,
  output rxStrobe_t strobe,
  output logic      inSession
);
  rxState_t state, nextState;
  logic     ackWant, nextWant, ackPhase, nextPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ackWant  <= 1'b0;
      ackPhase <= 1'b0;
    end else begin
      state    <= nextState;
      ackWant  <= nextWant;
      ackPhase <= nextPhase;
    end
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextWant  = ackWant;
    nextPhase = ackPhase;
    if (startDet) begin
      strobe.clearFlags = 1'b1;
      strobe.cntClr     = 1'b1;
      strobe.ackClr     = 1'b1;
      nextState         = ST_ADDR;
      nextPhase         = 1'b0;
    end else if (stopDet) begin
      strobe.ackClr = 1'b1;
      nextState     = ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR: if (sclRise) begin
          strobe.shiftEn = 1'b1;
          if (bitLast) begin
            strobe.evalAddr = 1'b1;
            nextWant        = ackEnable;
            nextPhase       = 1'b0;
            nextState       = addrHit ? ST_ADDR_ACK : ST_SKIP;
          end
        end
        ST_DATA: if (sclRise) begin
          strobe.shiftEn = 1'b1;
          if (bitLast) begin
            strobe.storeData = armed;
            nextWant         = armed && ackEnable;
            nextPhase        = 1'b0;
            nextState        = ST_DATA_ACK;
          end
        end
        ST_ADDR_ACK, ST_DATA_ACK: if (sclFall) begin
          if (!ackPhase) begin
            strobe.ackSet = ackWant;
            nextPhase     = 1'b1;
          end else begin
            strobe.ackClr = 1'b1;
            strobe.cntClr = 1'b1;
            nextState     = ST_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  assign inSession = (state != ST_IDLE);
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_rx_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-2:0] ownAddr,
  input  logic              ackEnable,
  input  logic              rearm,
  output logic              sdaPullLow,
  output logic              irq,
  output logic              genCallFlag,
  output logic              addrMatchFlag,
  output logic              inSession,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid
);
  localparam int ADDR_W = BYTE_W - 1;

  rxStrobe_t strobe;
  logic startDet, stopDet, sclRise, sclFall, bitLast, addrHit, armed;

  i2c_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startDet(startDet), .stopDet(stopDet),
    .sclRise(sclRise), .sclFall(sclFall), .bitLast(bitLast),
    .addrHit(addrHit), .armed(armed), .ackEnable(ackEnable),
    .strobe(strobe), .inSession(inSession)
  );

  i2c_rx_datapath #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ownAddr(ownAddr),
    .rearm(rearm), .strobe(strobe), .startDet(startDet), .stopDet(stopDet),
    .sclRise(sclRise), .sclFall(sclFall), .bitLast(bitLast), .addrHit(addrHit),
    .armed(armed), .irq(irq), .genCallFlag(genCallFlag),
    .addrMatchFlag(addrMatchFlag), .sdaPullLow(sdaPullLow),
    .rxData(rxData), .rxValid(rxValid)
  );
endmodule

// File: rtl/i2c_rx_checker.sv
module i2c_rx_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              irq,
  input logic              genCallFlag,
  input logic              addrMatchFlag,
  input logic              inSession,
  input logic              sdaPullLow,
  input logic              rearm,
  input logic [BYTE_W-1:0] rxData,
  input logic              rxValid
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(genCallFlag && addrMatchFlag)); // R3

  AST_IRQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq); // R4

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (genCallFlag || addrMatchFlag)); // R5

  AST_IDLE_NO_PULL: assert property (@(posedge clk) disable iff (!rstN)
    !inSession |-> !sdaPullLow); // R1

  AST_HELD_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rearm) |=> $stable(rxData)); // R9
endmodule

bind i2c_slave_rx i2c_rx_checker #(.BYTE_W(BYTE_W)) u_checker (
  .clk(clk), .rstN(rstN), .irq(irq), .genCallFlag(genCallFlag),
  .addrMatchFlag(addrMatchFlag), .inSession(inSession), .sdaPullLow(sdaPullLow),
  .rearm(rearm), .rxData(rxData), .rxValid(rxValid)
);

// File: tb/test_i2c_slave_rx.sv
module test_i2c_slave_rx;
  localparam int HALF = 8;
  localparam logic [6:0] OWN = 7'h52;   // address byte 8'hA4

  // {addressByte, ackEnable, expGenCall, expMatch, expAck}
  localparam int NVEC = 7;
  localparam logic [11:0] VEC [NVEC] = '{
    {8'hA4, 4'b1011}, {8'h00, 4'b1101}, {8'hA5, 4'b1000}, {8'hA6, 4'b1000},
    {8'hA4, 4'b0010}, {8'h00, 4'b0100}, {8'h24, 4'b1000}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, ackEnable = 1'b1, rearm = 1'b0;
  logic sdaPullLow, irq, genCallFlag, addrMatchFlag, inSession, rxValid;
  logic [7:0] rxData;
  logic sdaBus;
  int checks = 0, fails = 0, irqCount = 0, cycles = 0;

  assign sdaBus = sdaM & ~sdaPullLow;

  always #2 clk = ~clk;

  i2c_slave_rx i_i2c_slave_rx (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .ownAddr(OWN),
    .ackEnable(ackEnable), .rearm(rearm), .sdaPullLow(sdaPullLow), .irq(irq),
    .genCallFlag(genCallFlag), .addrMatchFlag(addrMatchFlag),
    .inSession(inSession), .rxData(rxData), .rxValid(rxValid)
  );

  always @(negedge clk) begin
    if (irq) irqCount++;
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(HALF);
    sclM = 1'b1; waitClk(HALF);
    sdaM = 1'b0; waitClk(HALF);
    sclM = 1'b0; waitClk(HALF);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClk(HALF);
    sclM = 1'b1; waitClk(HALF);
    sdaM = 1'b1; waitClk(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitClk(HALF);
      sclM = 1'b1; waitClk(HALF);
      sclM = 1'b0;
    end
    sdaM = 1'b1; waitClk(HALF);
    sclM = 1'b1; waitClk(HALF / 2);
    acked = ~sdaBus;
    waitClk(HALF / 2);
    sclM = 1'b0; waitClk(HALF);
  endtask

  task automatic pulseRearm();
    rearm = 1'b1; waitClk(1);
    rearm = 1'b0; waitClk(1);
  endtask

  initial begin
    logic ack;
    int irqBefore;
    waitClk(4);
    // R11: reset values
    check({sdaPullLow, irq, genCallFlag, addrMatchFlag, inSession, rxValid} == 6'b0 && rxData == 8'h00,
          "R11 reset outputs", {genCallFlag, addrMatchFlag, inSession, rxValid}, 0);
    rstN = 1'b1; waitClk(4);

    for (int v = 0; v < NVEC; v++) begin
      ackEnable = VEC[v][3];
      irqBefore = irqCount;
      busStart();
      check(inSession == 1'b1, "R1 session after START", inSession, 1);
      sendByte(VEC[v][11:4], ack);
      check(genCallFlag == VEC[v][2], "R3 general-call flag", genCallFlag, VEC[v][2]);
      check(addrMatchFlag == VEC[v][1], "R4 own-address flag", addrMatchFlag, VEC[v][1]);
      check(irqCount - irqBefore == int'(VEC[v][2] | VEC[v][1]), "R5 irq count",
            irqCount - irqBefore, int'(VEC[v][2] | VEC[v][1]));
      check(ack == VEC[v][0], VEC[v][3] ? "R6 acknowledge" : "R7 no acknowledge", ack, VEC[v][0]);
      busStop();
      waitClk(4);
      check(inSession == 1'b0, "R1 session ends at STOP", inSession, 0);
    end

    // R8 / R2: armed data bytes, MSB first, no irq for data
    ackEnable = 1'b1;
    busStart();
    sendByte(8'hA4, ack);
    irqBefore = irqCount;
    pulseRearm();
    sendByte(8'h1D, ack);
    check(rxData == 8'h1D, "R2 MSB-first data", rxData, 8'h1D);
    check(rxValid == 1'b1, "R8 rxValid set", rxValid, 1);
    check(ack == 1'b1, "R6 data acknowledge", ack, 1);
    check(irqCount == irqBefore, "R8 no irq on data", irqCount, irqBefore);
    pulseRearm();
    check(rxValid == 1'b0, "R8 rearm clears rxValid", rxValid, 0);
    sendByte(8'hC3, ack);
    check(rxData == 8'hC3, "R8 second byte", rxData, 8'hC3);

    // R9: not armed -> ignored
    sendByte(8'h55, ack);
    check(rxData == 8'hC3 && rxValid, "R9 unarmed byte kept old data", rxData, 8'hC3);
    check(ack == 1'b0, "R9 unarmed byte not acknowledged", ack, 0);

    // R7: ack off still stores
    ackEnable = 1'b0;
    pulseRearm();
    sendByte(8'h6E, ack);
    check(rxData == 8'h6E && ack == 1'b0, "R7 stored without acknowledge", {ack, rxData}, 8'h6E);

    // R10: repeated START clears flags and re-compares
    ackEnable = 1'b1;
    busStart();
    check(addrMatchFlag == 1'b0 && genCallFlag == 1'b0, "R10 flags cleared by repeated START",
          {genCallFlag, addrMatchFlag}, 0);
    sendByte(8'h00, ack);
    check(genCallFlag == 1'b1 && addrMatchFlag == 1'b0, "R10 re-compared as general call",
          {genCallFlag, addrMatchFlag}, 2);

    // R5: after a miss, armed data bytes are ignored
    busStart();
    sendByte(8'h24, ack);
    pulseRearm();
    sendByte(8'h77, ack);
    check(rxValid == 1'b0 && rxData == 8'h6E, "R5 data after miss ignored", rxData, 8'h6E);
    check(ack == 1'b0, "R5 data after miss not acknowledged", ack, 0);
    busStop();
    waitClk(4);
    check(inSession == 1'b0, "R1 final STOP", inSession, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule